// File: doc/BRIEF.md
# Masked-Write PHY Control Register Bank

This block is a small register file that configures the digital side of a memory-card PHY. It has seven 16-bit control words and one read-only status word, reached over a plain register port: address, write data, write strobe, read strobe and read data. Each 32-bit write carries its own mask in the upper half. Bit 16+x of the written word lets lower bit x take the new value. Any lower bit whose mask bit is clear keeps what it held. The mask itself is never stored.

The control fields that the PHY consumes leave the block as output ports, decoded straight from the stored words:
- power-up (active-high, so low means powered down)
- DLL enable
- drive-strength code
- clock-frequency select
- output tap-delay enable and tap-delay value

Two status inputs, calibration-complete and DLL-locked, are sampled when software reads the status word. Software sequences the PHY by writing single bits under a one-bit mask, so it never has to read, modify and write back a word.

Top module: `phyctl_regbank`

## Requirements
- R1: On a write to a control word, stored bit x (0..15) takes wrData[x] if wrData[x+16] is 1 and otherwise keeps its previous value.
- R2: Control words sit at byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 and are independent of one another. A read raises rdData one cycle after rdEn to {16'h0, stored word}. In a cycle that follows no read, rdData is 0.
- R3: The word at 0x18 drives three fields. pwrUp is bit 0 and dllEn is bit 1. driveSel is bits 6:4, with codes 0=50, 1=33, 2=66, 3=100 and 4=40 ohm.
- R4: The word at 0x00 drives three fields. freqSel is bits 13:12, with codes 0=200, 1=50, 2=100 and 3=150 MHz. tapDlyEn is bit 11 and tapDly is bits 10:7.
- R5: A read of address 0x20 returns calDone in bit 6 and dllReady in bit 5, with all other bits 0. Writes to 0x20 change nothing.
- R6: While rstN is low, every stored bit, every field output and rdData are 0.
- R7: The following addresses are unmapped: 0x1C, any address above 0x20, and any address with addr[1:0] != 0. Reads of an unmapped address return 0, and writes to one change nothing.
- R8: When a read and a write reach the same word in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address |
| wrData | input | 32 | Write data: mask in [31:16], value in [15:0] |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Read result, registered |
| pwrUp | output | 1 | Power-up control (word 0x18 bit 0) |
| dllEn | output | 1 | DLL enable (word 0x18 bit 1) |
| driveSel | output | 3 | Drive-strength code (word 0x18 bits 6:4) |
| freqSel | output | 2 | Frequency select (word 0x00 bits 13:12) |
| tapDlyEn | output | 1 | Output tap-delay enable (word 0x00 bit 11) |
| tapDly | output | 4 | Output tap-delay value (word 0x00 bits 10:7) |
| calDone | input | 1 | Calibration-complete status |
| dllReady | input | 1 | DLL-locked status |

## Verification
The masked write is tried with four mask patterns:
- A full mask, which shows that values land.
- An empty mask, which shows that nothing moves.
- A partial nibble mask, which shows that bits are chosen one by one.
- A byte-wide mask with mixed data.

Each control word gets a distinct value, so a decode that aliases two words shows up on read-back. Field ports are compared after single-bit and multi-bit masked writes, so a misplaced bit position is told apart from a masking fault. Misaligned, gap and out-of-range addresses, as well as status writes, are followed by read-backs of the words they could have disturbed. A read and a write to the same word in one cycle show whether the read returns the old value or the new one.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;
  localparam int DATA_W      = 32;
  localparam int HALF_W      = DATA_W / 2;
  localparam int CTRL_REGS   = 7;
  localparam int IDX_W       = $clog2(CTRL_REGS);
  localparam int STATUS_WORD = 8;

  // field placement
  localparam int PWR_REG   = 6;
  localparam int PWR_BIT   = 0;
  localparam int DLL_BIT   = 1;
  localparam int DRV_LSB   = 4;
  localparam int DRV_W     = 3;
  localparam int CLK_REG   = 0;
  localparam int FREQ_LSB  = 12;
  localparam int FREQ_W    = 2;
  localparam int TAPEN_BIT = 11;
  localparam int TAP_LSB   = 7;
  localparam int TAP_W     = 4;
  localparam int STAT_CAL_BIT = 6;
  localparam int STAT_DLL_BIT = 5;

  typedef struct packed {
    logic [CTRL_REGS-1:0] wrSel;
    logic                 rdCtrl;
    logic                 rdStatus;
    logic [IDX_W-1:0]     rdIdx;
  } strobe_t;
endpackage

// File: rtl/phyctl_decode.sv
module phyctl_decode
  import phyctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           strb
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  logic              aligned;
  logic              ctrlHit;

  assign wordIdx = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign ctrlHit = aligned && (wordIdx < WIDX_W'(CTRL_REGS));

  genvar i;
  generate
    for (i = 0; i < CTRL_REGS; i++) begin : g_sel
      assign strb.wrSel[i] = wrEn && aligned && (wordIdx == WIDX_W'(i));
    end
  endgenerate

  assign strb.rdCtrl   = rdEn && ctrlHit;
  assign strb.rdStatus = rdEn && aligned && (wordIdx == WIDX_W'(STATUS_WORD));
  assign strb.rdIdx    = wordIdx[IDX_W-1:0];
endmodule

// File: rtl/phyctl_store.sv
module phyctl_store
  import phyctl_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          strb,
  input  logic [DATA_W-1:0]                wrData,
  input  logic                             calDone,
  input  logic                             dllReady,
  output logic [CTRL_REGS-1:0][HALF_W-1:0] regWord,
  output logic [DATA_W-1:0]                rdData
);
  logic [HALF_W-1:0] wrMask;
  logic [HALF_W-1:0] wrVal;
  logic [DATA_W-1:0] rdNext;
  logic [HALF_W-1:0] ctrlView;

  assign wrMask = wrData[DATA_W-1:HALF_W];
  assign wrVal  = wrData[HALF_W-1:0];

  genvar i;
  generate
    for (i = 0; i < CTRL_REGS; i++) begin : g_word
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          regWord[i] <= '0;
        else if (strb.wrSel[i])
          regWord[i] <= (regWord[i] & ~wrMask) | (wrVal & wrMask);
      end
    end
  endgenerate

  always_comb begin
    ctrlView = '0;
    for (int k = 0; k < CTRL_REGS; k++) begin
      if (strb.rdIdx == IDX_W'(k)) ctrlView = regWord[k];
    end
  end

  always_comb begin
    rdNext = '0;
    if (strb.rdCtrl) begin
      rdNext[HALF_W-1:0] = ctrlView;
    end else if (strb.rdStatus) begin
      rdNext[STAT_CAL_BIT] = calDone;
      rdNext[STAT_DLL_BIT] = dllReady;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end
endmodule

// File: rtl/phyctl_regbank.sv
module phyctl_regbank
  import phyctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [31:0]       rdData,
  output logic              pwrUp,
  output logic              dllEn,
  output logic [2:0]        driveSel,
  output logic [1:0]        freqSel,
  output logic              tapDlyEn,
  output logic [3:0]        tapDly,
  input  logic              calDone,
  input  logic              dllReady
);
  strobe_t                          strb;
  logic [CTRL_REGS-1:0][HALF_W-1:0] regWord;

  phyctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .strb (strb)
  );

  phyctl_store u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .calDone  (calDone),
    .dllReady (dllReady),
    .regWord  (regWord),
    .rdData   (rdData)
  );

  assign pwrUp    = regWord[PWR_REG][PWR_BIT];
  assign dllEn    = regWord[PWR_REG][DLL_BIT];
  assign driveSel = regWord[PWR_REG][DRV_LSB +: DRV_W];
  assign freqSel  = regWord[CLK_REG][FREQ_LSB +: FREQ_W];
  assign tapDlyEn = regWord[CLK_REG][TAPEN_BIT];
  assign tapDly   = regWord[CLK_REG][TAP_LSB +: TAP_W];
endmodule

// File: rtl/phyctl_regbank_chk.sv
module phyctl_regbank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic              wrEn,
  input logic              rdEn,
  input logic [31:0]       rdData,
  input logic              pwrUp,
  input logic              dllEn,
  input logic [2:0]        driveSel,
  input logic [1:0]        freqSel,
  input logic              tapDlyEn,
  input logic [3:0]        tapDly,
  input logic              calDone,
  input logic              dllReady
);
  logic [12:0] fields;
  logic        unmapped;
  logic        statusAddr;

  assign fields     = {pwrUp, dllEn, driveSel, freqSel, tapDlyEn, tapDly};
  assign statusAddr = (addr == ADDR_W'(8'h20));
  assign unmapped   = (addr[1:0] != 2'b00) || (addr == ADDR_W'(8'h1C)) ||
                      (addr > ADDR_W'(8'h20));

  // R1
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[31:16] == 16'h0) |=> $stable(fields));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[31:16] == 16'h0);

  // R2
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == 32'h0));

  // R3
  pwr_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(8'h18) && wrData[16]) |=> (pwrUp == $past(wrData[0])));

  // R5
  status_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && statusAddr) |=>
      (rdData == {25'h0, $past(calDone), $past(dllReady), 5'h0}));

  // R5
  status_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && statusAddr) |=> $stable(fields));

  // R7
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && unmapped) |=> $stable(fields));

  // R7
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && unmapped) |=> (rdData == 32'h0));
endmodule

bind phyctl_regbank phyctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
  .rdEn(rdEn), .rdData(rdData), .pwrUp(pwrUp), .dllEn(dllEn),
  .driveSel(driveSel), .freqSel(freqSel), .tapDlyEn(tapDlyEn),
  .tapDly(tapDly), .calDone(calDone), .dllReady(dllReady)
);

// File: tb/sim_phyctl_regbank.sv
`timescale 1ns/1ps
module sim_phyctl_regbank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        pwrUp, dllEn, tapDlyEn;
  logic [2:0]  driveSel;
  logic [1:0]  freqSel;
  logic [3:0]  tapDly;
  logic        calDone = 1'b0;
  logic        dllReady = 1'b0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  phyctl_regbank u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .pwrUp(pwrUp), .dllEn(dllEn),
    .driveSel(driveSel), .freqSel(freqSel), .tapDlyEn(tapDlyEn),
    .tapDly(tapDly), .calDone(calDone), .dllReady(dllReady)
  );

  // {addr, write data, expected read-back}: write then read the same address
  localparam logic [71:0] VEC [14] = '{
    {8'h00, 32'hFFFF_A5A5, 32'h0000_A5A5},  // R1 full mask
    {8'h00, 32'h00F0_0F0F, 32'h0000_A505},  // R1 partial nibble mask
    {8'h04, 32'h0000_FFFF, 32'h0000_0000},  // R1 empty mask
    {8'h04, 32'hFF00_1234, 32'h0000_1200},  // R1 byte mask
    {8'h1C, 32'hFFFF_FFFF, 32'h0000_0000},  // R7 gap
    {8'h20, 32'hFFFF_FFFF, 32'h0000_0000},  // R5 status, inputs low
    {8'h18, 32'h0073_0071, 32'h0000_0071},  // R3
    {8'h14, 32'hFFFF_BEEF, 32'h0000_BEEF},  // R2
    {8'h02, 32'hFFFF_FFFF, 32'h0000_0000},  // R7 misaligned
    {8'h00, 32'h0000_0000, 32'h0000_A505},  // R7 misaligned write left word 0
    {8'h08, 32'hFFFF_0008, 32'h0000_0008},  // R2
    {8'h0C, 32'hFFFF_000C, 32'h0000_000C},  // R2
    {8'h10, 32'hFFFF_0010, 32'h0000_0010},  // R2
    {8'h24, 32'hFFFF_FFFF, 32'h0000_0000}   // R7 above range
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [7:0] a, input logic [31:0] d,
                        input logic we, input logic re);
    @(negedge clk);
    addr = a; wrData = d; wrEn = we; rdEn = re;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  initial begin
    #(10 * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset fields", {19'h0, pwrUp, dllEn, driveSel, freqSel, tapDlyEn, tapDly}, 32'h0);
    check("R6 reset rdData", rdData, 32'h0);
    rstN = 1'b1;
    access(8'h00, 32'h0, 1'b0, 1'b1);
    check("R6 word0 after reset", rdData, 32'h0);

    for (int i = 0; i < 14; i++) begin
      access(VEC[i][71:64], VEC[i][63:32], 1'b1, 1'b0);
      access(VEC[i][71:64], 32'h0, 1'b0, 1'b1);
      check($sformatf("R1/R2 vec %0d", i), rdData, VEC[i][31:0]);
    end

    // independence of words after later writes
    access(8'h04, 32'h0, 1'b0, 1'b1);
    check("R2 word 0x04 kept", rdData, 32'h0000_1200);
    access(8'h14, 32'h0, 1'b0, 1'b1);
    check("R2 word 0x14 kept", rdData, 32'h0000_BEEF);
    @(negedge clk);
    check("R2 idle rdData zero", rdData, 32'h0);

    // R3 fields from 0x71
    check("R3 pwrUp", {31'h0, pwrUp}, 32'h1);
    check("R3 dllEn", {31'h0, dllEn}, 32'h0);
    check("R3 driveSel", {29'h0, driveSel}, 32'h7);
    access(8'h18, 32'h0072_0042, 1'b1, 1'b0);
    check("R3 pwrUp held", {31'h0, pwrUp}, 32'h1);
    check("R3 dllEn set", {31'h0, dllEn}, 32'h1);
    check("R3 driveSel 40ohm", {29'h0, driveSel}, 32'h4);

    // R4 fields from word 0 = A505
    check("R4 freqSel", {30'h0, freqSel}, 32'h2);
    check("R4 tapDly", {28'h0, tapDly}, 32'hA);
    check("R4 tapDlyEn off", {31'h0, tapDlyEn}, 32'h0);
    access(8'h00, 32'h0800_0800, 1'b1, 1'b0);
    check("R4 tapDlyEn on", {31'h0, tapDlyEn}, 32'h1);
    check("R4 tapDly kept", {28'h0, tapDly}, 32'hA);

    // R5 status
    calDone = 1'b1; dllReady = 1'b0;
    access(8'h20, 32'h0, 1'b0, 1'b1);
    check("R5 calDone bit", rdData, 32'h0000_0040);
    dllReady = 1'b1;
    access(8'h20, 32'hFFFF_0000, 1'b1, 1'b1);
    check("R5 both bits", rdData, 32'h0000_0060);
    access(8'h20, 32'h0, 1'b0, 1'b1);
    check("R5 write ignored", rdData, 32'h0000_0060);

    // R8 same-cycle read and write
    access(8'h14, 32'hFFFF_0000, 1'b1, 1'b1);
    check("R8 old value", rdData, 32'h0000_BEEF);
    access(8'h14, 32'h0, 1'b0, 1'b1);
    check("R8 new value", rdData, 32'h0);

    // R6 reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R6 fields cleared", {19'h0, pwrUp, dllEn, driveSel, freqSel, tapDlyEn, tapDly}, 32'h0);
    rstN = 1'b1;
    access(8'h04, 32'h0, 1'b0, 1'b1);
    check("R6 word cleared", rdData, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule